// File: doc/BRIEF.md
# I2C Slave Controller with Overflow-Gated Acknowledge

This block is an I2C bus slave that watches open-drain SCL and SDA lines and talks to the rest of the chip through a small four-register bus. It recognises start and stop conditions and matches either a 7-bit address or a two-byte 10-bit address against a programmable own address. Bytes addressed to it are shifted in MSB first and acknowledged by the block itself. They are then copied into a single receive/transmit buffer.

The acknowledge depends on two status bits. If the previous byte is still unread (buffer full), or an overflow is still pending, the block does not acknowledge and keeps the buffer as it is. The interrupt flag is still raised so that software notices the lost byte. When the master sends a read address, the block becomes a transmitter. It takes each outgoing byte from the buffer at the moment the master acknowledges the previous one. The block never stretches the clock, so software must have the next byte in place in time.

Top module: `i2c_slave_port`

## Requirements
- R1: After reset every register reads 0x00, irq_o is 0 and sda_oe_o is 0.
- R2: While the enable bit (control bit 2) is 0, sda_oe_o stays 0 and bus activity is ignored: no start is recorded and no address is acknowledged.
- R3: A start condition (SDA falls while SCL is high) sets status bit 1 and clears status bit 2. A stop condition (SDA rises while SCL is high) sets status bit 2 and clears status bit 1.
- R4: Start and stop raise the interrupt flag (status bit 7, mirrored on irq_o) only when control bit 1 is set (modes 2 and 3). Writing status with bit 7 = 1 clears the flag.
- R5: In 7-bit mode (control bit 0 = 0), a first byte whose upper seven bits equal own-address bits 6:0 and whose bit 0 is 0 is acknowledged. The byte is loaded into the buffer and sets buffer-full (status bit 0) and the interrupt flag. Any other address gets no acknowledge and raises no interrupt.
- R6: Each data byte after an accepted write address is acknowledged and loaded into the buffer, and it sets buffer-full and the interrupt flag.
- R7: If buffer-full or overflow is set when a byte completes, there is no acknowledge and the buffer keeps its value, but the interrupt flag is still set.
- R8: A byte refused while buffer-full is set sets the overflow bit (control bit 3). Only a control write with bit 3 = 0 clears overflow. A read of the buffer (offset 2) clears buffer-full.
- R9: In 10-bit mode (control bit 0 = 1), a first byte of 11110, control bits 5:4, 0 is acknowledged and loaded. A second byte equal to own-address bits 7:0 is then acknowledged and loaded. A different second byte gets no acknowledge and no interrupt.
- R10: In 10-bit mode, a first byte of 11110, control bits 5:4, 1 after a repeated start is acknowledged and starts transmission, but only if the full 10-bit address has matched since the last stop. Otherwise it is not acknowledged.
- R11: A 7-bit read address (bit 0 = 1) is acknowledged, leaves the buffer unchanged and sets status bit 3. The buffer byte is sent MSB first, and a new byte is taken from the buffer on each master acknowledge. A master not-acknowledge ends transmission and clears status bit 3.
- R12: The register offsets are 0 for control, 1 for status, 2 for the buffer and 3 for own-address bits 7:0. A software write to the buffer does not set buffer-full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain) |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (side effects) |
| addr_i | input | 2 | Register offset |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt flag |

## Verification
The assertions assume that SCL and SDA change only through a well-formed master. SDA moves only while SCL is low, except at start and stop. Each SCL level also lasts several system clocks longer than the two-stage synchroniser delay. The bench master meets this by holding every quarter bit for eight clocks and by changing SDA only after SCL has been low for a full quarter. It models the open-drain line as the AND of the master level and the inverse of sda_oe_o. Register accesses happen only between bytes, so buffer reads never race a buffer load.

// File: rtl/i2c_slave_pkg.sv
package i2c_slave_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 10;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_BUF  = 2'd2;
  localparam logic [1:0] REG_OWN  = 2'd3;

  localparam logic [4:0] TEN_PREFIX = 5'b11110;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_ADDR2,
    PH_RX,
    PH_TX
  } phase_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  // idle bus level is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], line_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_slave_pkg::*;
(
  input  phase_e                  phase_i,
  input  logic                    ten_bit_i,
  input  logic [BYTE_W-1:0]       byte_i,
  input  logic [ADDR_W-1:0]       own_i,
  input  logic                    hit10_i,
  output logic                    hit_o,
  output phase_e                  next_o,
  output logic                    load_o,
  output logic                    set10_o
);
  always_comb begin
    hit_o   = 1'b0;
    next_o  = PH_IDLE;
    load_o  = 1'b0;
    set10_o = 1'b0;
    case (phase_i)
      PH_ADDR: begin
        if (ten_bit_i) begin
          if (byte_i == {TEN_PREFIX, own_i[9:8], 1'b0}) begin
            hit_o  = 1'b1;
            next_o = PH_ADDR2;
            load_o = 1'b1;
          end else if (hit10_i && byte_i == {TEN_PREFIX, own_i[9:8], 1'b1}) begin
            hit_o  = 1'b1;
            next_o = PH_TX;
          end
        end else if (byte_i[7:1] == own_i[6:0]) begin
          hit_o  = 1'b1;
          next_o = byte_i[0] ? PH_TX : PH_RX;
          load_o = ~byte_i[0];
        end
      end
      PH_ADDR2: begin
        if (byte_i == own_i[7:0]) begin
          hit_o   = 1'b1;
          next_o  = PH_RX;
          load_o  = 1'b1;
          set10_o = 1'b1;
        end
      end
      PH_RX: begin
        hit_o  = 1'b1;
        next_o = PH_RX;
        load_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/i2c_slave_engine.sv
module i2c_slave_engine
  import i2c_slave_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              ten_bit_i,
  input  logic [ADDR_W-1:0] own_i,
  input  logic              bf_i,
  input  logic              ovf_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              load_o,
  output logic              refuse_o,
  output logic              note_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              tx_mode_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk_i, .rst_ni, .line_i(scl_i),
    .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
  );
  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk_i, .rst_ni, .line_i(sda_i),
    .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  wire start_det = sda_fall & scl_lvl;
  wire stop_det  = sda_rise & scl_lvl;

  phase_e            phase_q, next_ph;
  logic [CNT_W-1:0]  cnt_q;
  logic              in_ack_q, hit10_q, mack_q;
  logic              ack_q, tx_drv_q;
  logic [BYTE_W-1:0] rx_sr_q, tx_sr_q;
  logic              hit, want_load, set10;

  i2c_addr_match u_match (
    .phase_i  (phase_q),
    .ten_bit_i(ten_bit_i),
    .byte_i   (rx_sr_q),
    .own_i    (own_i),
    .hit10_i  (hit10_q),
    .hit_o    (hit),
    .next_o   (next_ph),
    .load_o   (want_load),
    .set10_o  (set10)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      in_ack_q <= 1'b0;
      hit10_q  <= 1'b0;
      mack_q   <= 1'b0;
      ack_q    <= 1'b0;
      tx_drv_q <= 1'b0;
      rx_sr_q  <= '0;
      tx_sr_q  <= '0;
      start_o  <= 1'b0;
      stop_o   <= 1'b0;
      load_o   <= 1'b0;
      refuse_o <= 1'b0;
      note_o   <= 1'b0;
    end else begin
      start_o  <= 1'b0;
      stop_o   <= 1'b0;
      load_o   <= 1'b0;
      refuse_o <= 1'b0;
      note_o   <= 1'b0;
      if (!en_i) begin
        phase_q  <= PH_IDLE;
        cnt_q    <= '0;
        in_ack_q <= 1'b0;
        hit10_q  <= 1'b0;
        ack_q    <= 1'b0;
        tx_drv_q <= 1'b0;
      end else if (start_det) begin
        phase_q  <= PH_ADDR;
        cnt_q    <= '0;
        in_ack_q <= 1'b0;
        ack_q    <= 1'b0;
        tx_drv_q <= 1'b0;
        start_o  <= 1'b1;
      end else if (stop_det) begin
        phase_q  <= PH_IDLE;
        cnt_q    <= '0;
        in_ack_q <= 1'b0;
        hit10_q  <= 1'b0;
        ack_q    <= 1'b0;
        tx_drv_q <= 1'b0;
        stop_o   <= 1'b1;
      end else if (phase_q != PH_IDLE) begin
        if (scl_rise) begin
          if (in_ack_q) begin
            mack_q <= ~sda_lvl;
          end else if (cnt_q < LAST_BIT) begin
            cnt_q <= cnt_q + 1'b1;
            if (phase_q != PH_TX) rx_sr_q <= {rx_sr_q[BYTE_W-2:0], sda_lvl};
          end
        end else if (scl_fall) begin
          if (in_ack_q) begin
            // end of acknowledge slot
            in_ack_q <= 1'b0;
            cnt_q    <= '0;
            ack_q    <= 1'b0;
            if (phase_q == PH_TX) begin
              if (mack_q) begin
                tx_sr_q  <= tx_byte_i;
                tx_drv_q <= 1'b1;
                note_o   <= 1'b1;
              end else begin
                phase_q  <= PH_IDLE;
              end
            end
          end else if (cnt_q == LAST_BIT) begin
            in_ack_q <= 1'b1;
            if (phase_q == PH_TX) begin
              tx_drv_q <= 1'b0;
            end else if (!hit) begin
              phase_q <= PH_IDLE;
            end else if (bf_i || ovf_i) begin
              // gated: no ACK, no load, flag only
              refuse_o <= 1'b1;
              if (phase_q != PH_RX) phase_q <= PH_IDLE;
            end else begin
              ack_q   <= 1'b1;
              phase_q <= next_ph;
              if (set10) hit10_q <= 1'b1;
              if (want_load) load_o <= 1'b1;
              else           note_o <= 1'b1;
            end
          end else if (phase_q == PH_TX && cnt_q != '0) begin
            tx_sr_q <= {tx_sr_q[BYTE_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign sda_oe_o  = ack_q | (tx_drv_q & ~tx_sr_q[BYTE_W-1]);
  assign byte_o    = rx_sr_q;
  assign tx_mode_o = (phase_q == PH_TX);
endmodule

// File: rtl/i2c_slave_regs.sv
module i2c_slave_regs
  import i2c_slave_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [1:0]        addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              load_i,
  input  logic              refuse_i,
  input  logic              note_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              tx_mode_i,
  output logic              en_o,
  output logic              ten_bit_o,
  output logic [ADDR_W-1:0] own_o,
  output logic              bf_o,
  output logic              ovf_o,
  output logic [BYTE_W-1:0] buf_o,
  output logic              irq_o,
  output logic              start_seen_o,
  output logic              stop_seen_o
);
  logic [1:0]        mode_q, hi_q;
  logic              en_q, ovf_q, bf_q, irq_q, start_q, stop_q;
  logic [BYTE_W-1:0] buf_q, own_lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= '0;
      hi_q     <= '0;
      en_q     <= 1'b0;
      ovf_q    <= 1'b0;
      bf_q     <= 1'b0;
      irq_q    <= 1'b0;
      start_q  <= 1'b0;
      stop_q   <= 1'b0;
      buf_q    <= '0;
      own_lo_q <= '0;
    end else begin
      if (wr_en_i) begin
        case (addr_i)
          REG_CTRL: begin
            mode_q <= wdata_i[1:0];
            en_q   <= wdata_i[2];
            ovf_q  <= wdata_i[3];
            hi_q   <= wdata_i[5:4];
          end
          REG_STAT: if (wdata_i[7]) irq_q <= 1'b0;
          REG_BUF:  buf_q <= wdata_i;
          default:  own_lo_q <= wdata_i;
        endcase
      end
      if (rd_en_i && addr_i == REG_BUF) bf_q <= 1'b0;
      // bus events take priority over software in the same cycle
      if (start_i) begin
        start_q <= 1'b1;
        stop_q  <= 1'b0;
        if (mode_q[1]) irq_q <= 1'b1;
      end
      if (stop_i) begin
        stop_q  <= 1'b1;
        start_q <= 1'b0;
        if (mode_q[1]) irq_q <= 1'b1;
      end
      if (load_i) begin
        buf_q <= byte_i;
        bf_q  <= 1'b1;
        irq_q <= 1'b1;
      end
      if (note_i) irq_q <= 1'b1;
      if (refuse_i) begin
        irq_q <= 1'b1;
        if (bf_q) ovf_q <= 1'b1;
      end
    end
  end

  always_comb begin
    case (addr_i)
      REG_CTRL: rdata_o = {2'b00, hi_q, ovf_q, en_q, mode_q};
      REG_STAT: rdata_o = {irq_q, 3'b000, tx_mode_i, stop_q, start_q, bf_q};
      REG_BUF:  rdata_o = buf_q;
      default:  rdata_o = own_lo_q;
    endcase
  end

  assign en_o         = en_q;
  assign ten_bit_o    = mode_q[0];
  assign own_o        = {hi_q, own_lo_q};
  assign bf_o         = bf_q;
  assign ovf_o        = ovf_q;
  assign buf_o        = buf_q;
  assign irq_o        = irq_q;
  assign start_seen_o = start_q;
  assign stop_seen_o  = stop_q;
endmodule

// File: rtl/i2c_slave_port.sv
module i2c_slave_port
  import i2c_slave_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_o
);
  logic              en, ten_bit, bf, ovf, start_seen, stop_seen;
  logic              start_p, stop_p, load_p, refuse_p, note_p, tx_mode;
  logic [ADDR_W-1:0] own;
  logic [BYTE_W-1:0] buf_q, rx_byte;

  i2c_slave_engine #(.SYNC_STAGES(SYNC_STAGES)) u_engine (
    .clk_i, .rst_ni,
    .en_i     (en),
    .ten_bit_i(ten_bit),
    .own_i    (own),
    .bf_i     (bf),
    .ovf_i    (ovf),
    .tx_byte_i(buf_q),
    .scl_i, .sda_i,
    .sda_oe_o,
    .start_o  (start_p),
    .stop_o   (stop_p),
    .load_o   (load_p),
    .refuse_o (refuse_p),
    .note_o   (note_p),
    .byte_o   (rx_byte),
    .tx_mode_o(tx_mode)
  );

  i2c_slave_regs u_regs (
    .clk_i, .rst_ni,
    .wr_en_i, .rd_en_i, .addr_i, .wdata_i, .rdata_o,
    .start_i     (start_p),
    .stop_i      (stop_p),
    .load_i      (load_p),
    .refuse_i    (refuse_p),
    .note_i      (note_p),
    .byte_i      (rx_byte),
    .tx_mode_i   (tx_mode),
    .en_o        (en),
    .ten_bit_o   (ten_bit),
    .own_o       (own),
    .bf_o        (bf),
    .ovf_o       (ovf),
    .buf_o       (buf_q),
    .irq_o,
    .start_seen_o(start_seen),
    .stop_seen_o (stop_seen)
  );
endmodule

// File: rtl/i2c_slave_port_chk.sv
module i2c_slave_port_chk
  import i2c_slave_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [1:0] addr_i,
  input logic       sda_oe_o,
  input logic       irq_o,
  input logic       en,
  input logic       bf,
  input logic       ovf,
  input logic       load_p,
  input logic       refuse_p,
  input logic [7:0] buf_q,
  input logic       start_seen,
  input logic       stop_seen
);
  a_r2_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> !sda_oe_o);

  a_r3_seen_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_seen && stop_seen));

  a_r6_load_sets_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_p |=> bf);

  a_r7_refuse_keeps_buf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refuse_p && !(wr_en_i && addr_i == REG_BUF) |=> $stable(buf_q));

  a_r7_refuse_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refuse_p |=> irq_o);

  a_r8_ovf_from_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refuse_p && bf |=> ovf);

  a_r8_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf && !(wr_en_i && addr_i == REG_CTRL) |=> ovf);
endmodule

bind i2c_slave_port i2c_slave_port_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .sda_oe_o  (sda_oe_o),
  .irq_o     (irq_o),
  .en        (en),
  .bf        (bf),
  .ovf       (ovf),
  .load_p    (load_p),
  .refuse_p  (refuse_p),
  .buf_q     (buf_q),
  .start_seen(start_seen),
  .stop_seen (stop_seen)
);

// File: tb/i2c_slave_port_test.sv
module i2c_slave_port_test;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       sda_oe, irq;
  wire        sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  i2c_slave_port uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // {ack expected, 7-bit address, data byte}
  localparam logic [15:0] VECS [0:5] = '{
    16'hAAA5, 16'h2B00, 16'hAA00, 16'hAAFF, 16'h1500, 16'hAA3C
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(2 * Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = ~sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      b[i] = sda_line; tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = ~mack; tick(Q);
    scl_m = 1'b1; tick(2 * Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic       ack;
    tick(4);
    rst_n = 1'b1;
    tick(2);

    // R1 reset state
    chk("R1 sda_oe", {7'd0, sda_oe}, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    for (int r = 0; r < 4; r++) begin
      reg_rd(r[1:0], d);
      chk("R1 reg", d, 8'h00);
    end

    // R2 disabled block ignores the bus
    reg_wr(2'd3, 8'h2A);
    bus_start;
    send_byte(8'h54, ack);
    chk("R2 no ack", {7'd0, ack}, 8'h00);
    bus_stop;
    reg_rd(2'd1, d);
    chk("R2 nothing recorded", d, 8'h00);

    // R12 buffer write leaves buffer-full clear
    reg_wr(2'd2, 8'h5A);
    reg_rd(2'd1, d);
    chk("R12 bf after write", d, 8'h00);
    reg_rd(2'd2, d);
    chk("R12 buf readback", d, 8'h5A);
    reg_wr(2'd0, 8'h04);
    reg_rd(2'd0, d);
    chk("R12 ctrl readback", d, 8'h04);

    // R3 start / stop status, R4 no irq in mode 0
    bus_start;
    reg_rd(2'd1, d);
    chk("R3 start seen", d, 8'h02);
    bus_stop;
    reg_rd(2'd1, d);
    chk("R3 stop seen", d, 8'h04);
    chk("R4 no irq mode0", {7'd0, irq}, 8'h00);

    // R4 start/stop irq in mode 2
    reg_wr(2'd0, 8'h06);
    bus_start;
    chk("R4 start irq", {7'd0, irq}, 8'h01);
    reg_wr(2'd1, 8'h80);
    chk("R4 irq cleared", {7'd0, irq}, 8'h00);
    bus_stop;
    chk("R4 stop irq", {7'd0, irq}, 8'h01);
    reg_wr(2'd1, 8'h80);
    reg_wr(2'd0, 8'h04);

    // R5 / R6 table of 7-bit write transactions
    for (int i = 0; i < 6; i++) begin
      logic [15:0] v;
      v = VECS[i];
      reg_wr(2'd1, 8'h80);
      bus_start;
      send_byte({v[14:8], 1'b0}, ack);
      chk("R5 address ack", {7'd0, ack}, {7'd0, v[15]});
      if (v[15]) begin
        reg_rd(2'd2, d);
        chk("R5 address loaded", d, {v[14:8], 1'b0});
        send_byte(v[7:0], ack);
        chk("R6 data ack", {7'd0, ack}, 8'h01);
        reg_rd(2'd1, d);
        chk("R6 status full+irq", d, 8'h83);
        reg_rd(2'd2, d);
        chk("R6 data loaded", d, v[7:0]);
      end else begin
        reg_rd(2'd1, d);
        chk("R5 mismatch no irq", d, 8'h02);
      end
      bus_stop;
    end

    // R7 / R8 overflow gating
    reg_wr(2'd1, 8'h80);
    bus_start;
    send_byte(8'h54, ack);
    reg_rd(2'd2, d);
    send_byte(8'h11, ack);
    chk("R6 first data ack", {7'd0, ack}, 8'h01);
    send_byte(8'h22, ack);
    chk("R7 refused while full", {7'd0, ack}, 8'h00);
    reg_rd(2'd0, d);
    chk("R8 overflow set", d, 8'h0C);
    reg_rd(2'd2, d);
    chk("R7 buffer kept", d, 8'h11);
    reg_wr(2'd1, 8'h80);
    send_byte(8'h33, ack);
    chk("R7 refused on overflow", {7'd0, ack}, 8'h00);
    chk("R7 irq on refusal", {7'd0, irq}, 8'h01);
    reg_rd(2'd1, d);
    chk("R8 bf cleared by read", d, 8'h82);
    reg_rd(2'd2, d);
    chk("R7 buffer kept again", d, 8'h11);
    bus_stop;
    reg_rd(2'd0, d);
    chk("R8 overflow sticky", d, 8'h0C);
    reg_wr(2'd0, 8'h04);
    reg_rd(2'd0, d);
    chk("R8 overflow cleared", d, 8'h04);
    bus_start;
    send_byte(8'h54, ack);
    reg_rd(2'd2, d);
    send_byte(8'h44, ack);
    chk("R8 ack after clear", {7'd0, ack}, 8'h01);
    reg_rd(2'd2, d);
    chk("R8 data after clear", d, 8'h44);
    bus_stop;

    // R11 7-bit slave transmit
    reg_wr(2'd2, 8'h96);
    reg_wr(2'd1, 8'h80);
    bus_start;
    send_byte(8'h55, ack);
    chk("R11 read address ack", {7'd0, ack}, 8'h01);
    reg_rd(2'd1, d);
    chk("R11 tx status", d, 8'h8A);
    reg_rd(2'd2, d);
    chk("R11 buffer untouched", d, 8'h96);
    reg_wr(2'd2, 8'h5B);
    recv_byte(1'b1, d);
    chk("R11 first tx byte", d, 8'h96);
    recv_byte(1'b0, d);
    chk("R11 second tx byte", d, 8'h5B);
    reg_rd(2'd1, d);
    chk("R11 tx ended", d & 8'h08, 8'h00);
    bus_stop;

    // R9 10-bit addressing, own = 2'b10 : C5
    reg_wr(2'd3, 8'hC5);
    reg_wr(2'd0, 8'h25);
    bus_start;
    send_byte(8'hF4, ack);
    chk("R9 first byte ack", {7'd0, ack}, 8'h01);
    reg_rd(2'd2, d);
    chk("R9 first byte loaded", d, 8'hF4);
    send_byte(8'hC5, ack);
    chk("R9 second byte ack", {7'd0, ack}, 8'h01);
    reg_rd(2'd2, d);
    chk("R9 second byte loaded", d, 8'hC5);
    send_byte(8'h77, ack);
    reg_rd(2'd2, d);
    chk("R9 data after 10-bit", d, 8'h77);
    bus_stop;
    bus_start;
    send_byte(8'hF4, ack);
    reg_rd(2'd2, d);
    reg_wr(2'd1, 8'h80);
    send_byte(8'hC6, ack);
    chk("R9 wrong low byte nack", {7'd0, ack}, 8'h00);
    chk("R9 wrong low byte no irq", {7'd0, irq}, 8'h00);
    bus_stop;

    // R10 10-bit read
    bus_start;
    send_byte(8'hF5, ack);
    chk("R10 read without match nack", {7'd0, ack}, 8'h00);
    bus_stop;
    bus_start;
    send_byte(8'hF4, ack);
    reg_rd(2'd2, d);
    send_byte(8'hC5, ack);
    reg_rd(2'd2, d);
    reg_wr(2'd2, 8'h81);
    bus_start;
    send_byte(8'hF5, ack);
    chk("R10 read after match ack", {7'd0, ack}, 8'h01);
    recv_byte(1'b0, d);
    chk("R10 tx byte", d, 8'h81);
    bus_stop;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule